// File: doc/BRIEF.md
# Cartridge Boot Loader

This block sits on the host side of a game-cartridge slot and brings a cartridge from power-up to a state where its identity and header are known. When `start` is pulsed, it pulses the cartridge reset low for one cycle and then releases it. It waits a programmable settle time, because some devices need roughly 19 ms or more and 30 ms is a safe setting. It then polls the 4-byte chip ID until a nonzero value arrives, waits an extra programmable interval, and fetches the header. The header is stored in an internal word buffer that the host reads back through a word address port.

The header fetch style is chosen at run time. If the platform flag `ext_platform` is set and bit 31 of the chip ID is 1, the header is fetched as a series of sector-sized pieces, each with its own read command and address. Otherwise it is fetched with one all-zero read command. An optional extended header at byte offset 3E00h can be fetched afterwards. It is judged valid by its first four bytes.

Commands leave as a byte stream with valid/ready. The loader holds `cmd_byte` and `cmd_valid` steady until `cmd_ready` is seen, and it may not withdraw a byte once it has offered it. Response words come in on `rsp_data` with `rsp_valid`/`rsp_ready`. A word transfers only on a cycle where both are high. The cartridge side may raise `rsp_valid` at any time, and the loader ignores it while `rsp_ready` is low. `xfer_words` gives the response length of the command in flight. The first-gap delay `gap_cycles` should be 657h or more, because about 380h gives occasional corrupt sectors. Configuration inputs must stay steady while `busy` is high.

Top module: `cart_boot_loader`

## Requirements
- R1: After `rst_n` is low, the outputs are as follows until `start`: `cart_rst_n`=0, `busy`=0, `done`=0, `err`=0, `ext_valid`=0, `cmd_valid`=0 and `rsp_ready`=0.
- R2: No command byte is offered while `cart_rst_n` is 0. The first command byte is offered exactly `settle_cycles`+1 cycles after `cart_rst_n` rises.
- R3: The chip ID command is the byte 90h followed by seven 00h bytes, with `xfer_words`=1.
- R4: A chip ID word of 0 causes a fresh ID command right after that word. The first nonzero word is latched on `chip_id`.
- R5: If the ID answer is still 0 after `max_polls` ID commands (at least one is always sent), `err` and `done` go high and no further command is offered.
- R6: The first header command byte is offered exactly `id_wait_cycles`+1 cycles after the nonzero ID word is accepted.
- R7: Split mode is used when `ext_platform`=1 and `chip_id[31]`=1, and `split_mode` shows it. In split mode the loader sends HDR_BYTES/SNIP_BYTES read commands, piece k first. Each command is byte 00h, then the address k*SNIP_BYTES as 4 bytes with the most significant byte first, then three 00h bytes, with `xfer_words`=SNIP_BYTES/4.
- R8: Otherwise one read command of eight 00h bytes is sent, with `xfer_words`=HDR_BYTES/4.
- R9: After the last byte of any command is accepted, `rsp_ready` rises exactly `gap_cycles`+1 cycles later and stays high until `xfer_words` words have been accepted. `rsp_valid` has no effect while `rsp_ready` is low.
- R10: Header response word n (header bytes 4n..4n+3, the lowest byte in bits 7:0) is stored at buffer word n. `rd_data` shows word `rd_addr` one cycle after `rd_addr` is applied.
- R11: When `ext_en`=1, the header is followed by a read command at address 3E00h with `xfer_words`=EXT_BYTES/4. `ext_valid` is 1 in the done state only if the first word of that read is 444C5754h, the bytes "T","W","L","D" in lanes 0..3. When `ext_en`=0 no such command is sent.
- R12: When `cmd_valid` is high and `cmd_ready` is low, `cmd_valid` and `cmd_byte` are unchanged in the next cycle. `cmd_valid` and `rsp_ready` are never high together.
- R13: A `start` while idle, done or failed clears the status, holds `cart_rst_n` low for one cycle, and runs the whole sequence again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous block reset |
| start | input | 1 | Begin (or restart) the power-up sequence |
| ext_platform | input | 1 | Host is the extended platform; enables split header fetch |
| ext_en | input | 1 | Also fetch the extended header at 3E00h |
| settle_cycles | input | TW | Cycles to wait after cartridge reset release |
| id_wait_cycles | input | TW | Extra cycles after a nonzero chip ID |
| gap_cycles | input | TW | First-gap delay between command and data |
| max_polls | input | 8 | Maximum number of chip ID commands |
| cart_rst_n | output | 1 | Cartridge reset, active low |
| cmd_byte | output | 8 | Command byte stream data |
| cmd_valid | output | 1 | Command byte valid |
| cmd_ready | input | 1 | Cartridge accepts command byte |
| xfer_words | output | XW | Response length, in words, of the current command |
| rsp_data | input | 32 | Response word |
| rsp_valid | input | 1 | Response word valid |
| rsp_ready | output | 1 | Loader accepts a response word |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence finished (with or without error) |
| err | output | 1 | Chip ID stayed zero for all polls |
| split_mode | output | 1 | Header was fetched in pieces |
| chip_id | output | 32 | Latched nonzero chip ID |
| ext_valid | output | 1 | Extended header signature matched |
| rd_addr | input | AW | Header buffer word address |
| rd_data | output | 32 | Header buffer word, one cycle after `rd_addr` |

## Verification
A corrupt piece counter or address step shows at the command port on the next read command. Its address bytes or `xfer_words` differ from k*SNIP_BYTES. It also shows later as wrong words at `rd_data`. A timer that loads the wrong value moves the first command byte or the rise of `rsp_ready` by a measurable number of cycles. A sequencer that takes the wrong branch after an ID word or after the last header word shows within one cycle: the wrong command starts, or `done`/`err` rise too early. A missed or extra word accepted during a gap or outside a read moves every following word by one lane in the buffer.

// File: rtl/cbl_pkg.sv
package cbl_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_HOLD, ST_SETTLE, ST_CMD, ST_GAP, ST_DATA, ST_IDWAIT, ST_DONE, ST_FAIL
  } cbl_state_e;

  typedef enum logic [1:0] { PH_ID, PH_HDR, PH_EXT } cbl_phase_e;

  localparam logic [63:0] CMD_CHIP_ID = {8'h90, 56'h0};
  localparam logic [31:0] EXT_MAGIC   = 32'h444C5754;

  // read command: opcode 00h, big-endian byte address, three zero bytes
  function automatic logic [63:0] read_cmd(input logic [31:0] addr);
    return {8'h00, addr, 24'h0};
  endfunction
endpackage

// File: rtl/cbl_timer.sv
module cbl_timer #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] value,
  output logic         zero
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= value;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/cbl_cmd_tx.sv
module cbl_cmd_tx #(
  parameter int NBYTES = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                go,
  input  logic [NBYTES*8-1:0] cmd,
  output logic [7:0]          out_byte,
  output logic                out_valid,
  input  logic                out_ready,
  output logic                last_acc
);
  localparam int IW = $clog2(NBYTES);
  localparam logic [IW-1:0] LAST = IW'(NBYTES - 1);

  logic [NBYTES*8-1:0] shreg;
  logic [IW-1:0]       idx;
  logic                hs;

  assign hs = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg     <= '0;
      idx       <= '0;
      out_valid <= 1'b0;
    end else if (go) begin
      shreg     <= cmd;
      idx       <= '0;
      out_valid <= 1'b1;
    end else if (hs) begin
      shreg <= shreg << 8;
      idx   <= idx + 1'b1;
      if (idx == LAST) out_valid <= 1'b0;
    end
  end

  assign out_byte = shreg[NBYTES*8-1 -: 8];
  assign last_acc = hs && (idx == LAST);
endmodule

// File: rtl/cbl_hdr_buf.sv
module cbl_hdr_buf #(
  parameter int DEPTH = 1024,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [31:0]   wdata,
  input  logic [AW-1:0] raddr,
  output logic [31:0]   rdata
);
  logic [31:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/cart_boot_loader.sv
module cart_boot_loader
  import cbl_pkg::*;
#(
  parameter int          HDR_BYTES  = 4096,
  parameter int          SNIP_BYTES = 512,
  parameter int          EXT_BYTES  = 512,
  parameter logic [31:0] EXT_ADDR   = 32'h0000_3E00,
  parameter int          TW         = 24,
  localparam int         HDR_WORDS  = HDR_BYTES / 4,
  localparam int         AW         = $clog2(HDR_WORDS),
  localparam int         XW         = $clog2(HDR_WORDS) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          ext_platform,
  input  logic          ext_en,
  input  logic [TW-1:0] settle_cycles,
  input  logic [TW-1:0] id_wait_cycles,
  input  logic [TW-1:0] gap_cycles,
  input  logic [7:0]    max_polls,
  output logic          cart_rst_n,
  output logic [7:0]    cmd_byte,
  output logic          cmd_valid,
  input  logic          cmd_ready,
  output logic [XW-1:0] xfer_words,
  input  logic [31:0]   rsp_data,
  input  logic          rsp_valid,
  output logic          rsp_ready,
  output logic          busy,
  output logic          done,
  output logic          err,
  output logic          split_mode,
  output logic [31:0]   chip_id,
  output logic          ext_valid,
  input  logic [AW-1:0] rd_addr,
  output logic [31:0]   rd_data
);
  localparam int SNIP_WORDS = SNIP_BYTES / 4;
  localparam int EXT_WORDS  = EXT_BYTES / 4;
  localparam int PIECES     = HDR_BYTES / SNIP_BYTES;
  localparam int PW         = $clog2(PIECES + 1);

  cbl_state_e st, st_n;
  cbl_phase_e ph, ph_n;
  logic [7:0]    polls, polls_n;
  logic [PW-1:0] piece, piece_n;
  logic [XW-1:0] left, left_n, xfer_n;
  logic [AW-1:0] widx, widx_n;
  logic [31:0]   id_n;
  logic          split_n, extm, extm_n;

  logic          go, tl, tz, last_acc, we;
  logic [63:0]   cmd;
  logic [TW-1:0] tv;
  logic [31:0]   next_addr;

  assign next_addr = (32'(piece) + 32'd1) * 32'(SNIP_BYTES);

  always_comb begin
    st_n = st; ph_n = ph; polls_n = polls; piece_n = piece; left_n = left;
    widx_n = widx; id_n = chip_id; split_n = split_mode; extm_n = extm;
    xfer_n = xfer_words;
    go = 1'b0; cmd = CMD_CHIP_ID; tl = 1'b0; tv = gap_cycles; we = 1'b0;
    unique case (st)
      ST_IDLE, ST_DONE, ST_FAIL: begin
        if (start) begin
          st_n = ST_HOLD; polls_n = '0; id_n = '0; split_n = 1'b0; extm_n = 1'b0;
        end
      end
      ST_HOLD: begin
        tl = 1'b1; tv = settle_cycles; st_n = ST_SETTLE;
      end
      ST_SETTLE: begin
        if (tz) begin
          go = 1'b1; cmd = CMD_CHIP_ID; xfer_n = XW'(1); ph_n = PH_ID;
          polls_n = 8'd1; st_n = ST_CMD;
        end
      end
      ST_CMD: begin
        if (last_acc) begin
          tl = 1'b1; tv = gap_cycles; left_n = xfer_words; st_n = ST_GAP;
        end
      end
      ST_GAP: begin
        if (tz) st_n = ST_DATA;
      end
      ST_DATA: begin
        if (rsp_valid) begin
          left_n = left - 1'b1;
          unique case (ph)
            PH_ID: begin
              if (rsp_data == '0) begin
                if (polls >= max_polls) st_n = ST_FAIL;
                else begin
                  go = 1'b1; cmd = CMD_CHIP_ID; xfer_n = XW'(1);
                  polls_n = polls + 8'd1; st_n = ST_CMD;
                end
              end else begin
                id_n = rsp_data; tl = 1'b1; tv = id_wait_cycles; st_n = ST_IDWAIT;
              end
            end
            PH_HDR: begin
              we = 1'b1; widx_n = widx + 1'b1;
              if (left == XW'(1)) begin
                if (split_mode && (piece != PW'(PIECES - 1))) begin
                  piece_n = piece + 1'b1; go = 1'b1; cmd = read_cmd(next_addr);
                  xfer_n = XW'(SNIP_WORDS); st_n = ST_CMD;
                end else if (ext_en) begin
                  ph_n = PH_EXT; go = 1'b1; cmd = read_cmd(EXT_ADDR);
                  xfer_n = XW'(EXT_WORDS); st_n = ST_CMD;
                end else begin
                  st_n = ST_DONE;
                end
              end
            end
            default: begin
              if (left == xfer_words) extm_n = (rsp_data == EXT_MAGIC);
              if (left == XW'(1)) st_n = ST_DONE;
            end
          endcase
        end
      end
      ST_IDWAIT: begin
        if (tz) begin
          split_n = ext_platform && chip_id[31];
          ph_n = PH_HDR; widx_n = '0; piece_n = '0; go = 1'b1;
          cmd = read_cmd(32'h0);
          xfer_n = split_n ? XW'(SNIP_WORDS) : XW'(HDR_WORDS);
          st_n = ST_CMD;
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= ST_IDLE; ph <= PH_ID; polls <= '0; piece <= '0; left <= '0;
      widx <= '0; chip_id <= '0; split_mode <= 1'b0; extm <= 1'b0; xfer_words <= '0;
    end else begin
      st <= st_n; ph <= ph_n; polls <= polls_n; piece <= piece_n; left <= left_n;
      widx <= widx_n; chip_id <= id_n; split_mode <= split_n; extm <= extm_n;
      xfer_words <= xfer_n;
    end
  end

  assign cart_rst_n = !(st == ST_IDLE || st == ST_HOLD);
  assign rsp_ready  = (st == ST_DATA);
  assign busy       = !(st == ST_IDLE || st == ST_DONE || st == ST_FAIL);
  assign done       = (st == ST_DONE || st == ST_FAIL);
  assign err        = (st == ST_FAIL);
  assign ext_valid  = extm && (st == ST_DONE);

  cbl_timer #(.W(TW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(tl), .value(tv), .zero(tz)
  );

  cbl_cmd_tx #(.NBYTES(8)) u_tx (
    .clk(clk), .rst_n(rst_n), .go(go), .cmd(cmd), .out_byte(cmd_byte),
    .out_valid(cmd_valid), .out_ready(cmd_ready), .last_acc(last_acc)
  );

  cbl_hdr_buf #(.DEPTH(HDR_WORDS), .AW(AW)) u_buf (
    .clk(clk), .we(we), .waddr(widx), .wdata(rsp_data), .raddr(rd_addr), .rdata(rd_data)
  );
endmodule

// File: rtl/cbl_checker.sv
module cbl_checker #(
  parameter int XW = 11
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cart_rst_n,
  input logic [7:0]    cmd_byte,
  input logic          cmd_valid,
  input logic          cmd_ready,
  input logic [XW-1:0] xfer_words,
  input logic          rsp_ready,
  input logic          busy,
  input logic          done,
  input logic          err,
  input logic          ext_valid,
  input logic          start
);
  assert_cmd_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_byte));

  assert_one_dir_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_valid && rsp_ready));

  assert_quiet_in_reset_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !cart_rst_n |-> !cmd_valid && !rsp_ready);

  assert_id_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_valid) && cmd_byte == 8'h90 |-> xfer_words == XW'(1));

  assert_err_final_R5: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done && !busy && !cmd_valid);

  assert_done_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> done);

  assert_ext_ok_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ext_valid |-> done && !err);

  assert_restart_pulse_R13: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !cart_rst_n);
endmodule

bind cart_boot_loader cbl_checker #(.XW(XW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cart_rst_n(cart_rst_n), .cmd_byte(cmd_byte),
  .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .xfer_words(xfer_words),
  .rsp_ready(rsp_ready), .busy(busy), .done(done), .err(err),
  .ext_valid(ext_valid), .start(start)
);

// File: tb/sim_cart_boot_loader.sv
`timescale 1ns/1ps
module sim_cart_boot_loader;
  localparam int HB = 128, SB = 16, EB = 16, TW = 16;
  localparam int HW = HB/4, SW = SB/4, EW = EB/4, NP = HB/SB;
  localparam int AW = $clog2(HW), XW = $clog2(HW) + 1;
  localparam logic [31:0] EXTA = 32'h0000_3E00;

  logic clk = 0, rst_n = 0, start = 0, ext_platform = 0, ext_en = 0;
  logic [TW-1:0] settle_cycles = 0, id_wait_cycles = 0, gap_cycles = 0;
  logic [7:0] max_polls = 3;
  logic cart_rst_n, cmd_valid, cmd_ready = 0, rsp_valid = 0, rsp_ready;
  logic [7:0] cmd_byte;
  logic [XW-1:0] xfer_words;
  logic [31:0] rsp_data = 0, chip_id, rd_data;
  logic busy, done, err, split_mode, ext_valid;
  logic [AW-1:0] rd_addr = 0;

  always #5 clk = ~clk;

  cart_boot_loader #(.HDR_BYTES(HB), .SNIP_BYTES(SB), .EXT_BYTES(EB), .EXT_ADDR(EXTA), .TW(TW)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .ext_platform(ext_platform), .ext_en(ext_en),
    .settle_cycles(settle_cycles), .id_wait_cycles(id_wait_cycles), .gap_cycles(gap_cycles),
    .max_polls(max_polls), .cart_rst_n(cart_rst_n), .cmd_byte(cmd_byte), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .xfer_words(xfer_words), .rsp_data(rsp_data), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .busy(busy), .done(done), .err(err), .split_mode(split_mode),
    .chip_id(chip_id), .ext_valid(ext_valid), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  int total = 0, bad = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] pat(input logic [31:0] a);
    return {a[15:0] ^ 16'hA55A, ~a[15:0]};
  endfunction

  // cartridge model state
  int zero_polls = 0, id_cmds = 0, hdr_cmds = 0, ext_cmds = 0;
  logic [31:0] id_val = 32'h1, ext_sig = 0;
  logic [31:0] hdr_addr [16];
  int hdr_xw [16];
  logic [7:0] cb [8];
  int nb = 0, cyc = 0, kind = 0, idx = 0, cnt = 0, xw = 0;
  bit pend = 0, settle_arm = 0, idw_arm = 0, gap_arm = 0;
  int settle_cnt = 0, idw_cnt = 0, gap_cnt = 0;
  logic [31:0] base = 0, idword = 0;

  function automatic logic [31:0] word_now();
    if (kind == 0) return idword;
    if (kind == 2) return (idx == 0) ? ext_sig : pat(EXTA + 32'(4*idx));
    return pat(base + 32'(4*idx));
  endfunction

  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      if (!cart_rst_n) begin
        nb = 0; pend = 0; rsp_valid = 0; cmd_ready = 0;
        settle_arm = 1; settle_cnt = 0; idw_arm = 0; gap_arm = 0;
      end else begin
        if (settle_arm) begin
          if (!cmd_valid) settle_cnt++;
          else begin
            chk(settle_cnt == int'(settle_cycles) + 1, "R2 settle", settle_cnt, int'(settle_cycles) + 1);
            settle_arm = 0;
          end
        end
        if (idw_arm) begin
          if (!cmd_valid) idw_cnt++;
          else begin
            chk(idw_cnt == int'(id_wait_cycles) + 1, "R6 id wait", idw_cnt, int'(id_wait_cycles) + 1);
            idw_arm = 0;
          end
        end
        if (gap_arm) begin
          if (!rsp_ready) gap_cnt++;
          else begin
            chk(gap_cnt == int'(gap_cycles) + 1, "R9 gap", gap_cnt, int'(gap_cycles) + 1);
            gap_arm = 0;
          end
        end
        cmd_ready = (cyc % 3 != 0);
        if (cmd_valid && cmd_ready) begin
          cb[nb] = cmd_byte;
          if (nb == 0) xw = int'(xfer_words);
          nb++;
          if (nb == 8) begin
            nb = 0; pend = 1; idx = 0; cnt = xw; gap_arm = 1; gap_cnt = 0;
            if (cb[0] == 8'h90) begin
              chk({cb[1],cb[2],cb[3],cb[4],cb[5],cb[6],cb[7]} == 56'h0 && xw == 1, "R3 id cmd", xw, 1);
              id_cmds++; kind = 0;
              idword = (id_cmds <= zero_polls) ? 32'h0 : id_val;
            end else begin
              base = {cb[1], cb[2], cb[3], cb[4]};
              chk(cb[0] == 8'h00 && {cb[5],cb[6],cb[7]} == 24'h0, "R7 read cmd form", {cb[0],cb[5],cb[6],cb[7]}, 0);
              if (base == EXTA) begin
                kind = 2; ext_cmds++;
                chk(xw == EW, "R11 ext length", xw, EW);
              end else begin
                kind = 1;
                if (hdr_cmds < 16) begin hdr_addr[hdr_cmds] = base; hdr_xw[hdr_cmds] = xw; end
                hdr_cmds++;
              end
            end
          end
        end
        if (pend) begin
          if (!rsp_ready) begin
            rsp_valid = 1; rsp_data = 32'hBAD0_0000 | 32'(cyc);   // R9 junk must be ignored
          end else begin
            rsp_valid = (cyc % 4 != 1);
            rsp_data = rsp_valid ? word_now() : 32'hBAD1_0000;
            if (rsp_valid) begin
              if (kind == 0 && idword != 0) begin idw_arm = 1; idw_cnt = 0; end
              idx++;
              if (idx == cnt) pend = 0;
            end
          end
        end else begin
          rsp_valid = cyc[0]; rsp_data = 32'hBAD2_0000;
        end
      end
    end
  end

  int wd = 0;
  initial begin
    forever begin
      @(posedge clk);
      wd++;
      if (wd > 150000) begin
        bad++; total++;
        $display("FAIL watchdog expired actual=%0d expected<150000", wd);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  task automatic run(input bit plat, input bit idhi, input bit exten, input bit good,
                     input int zp, input int mp, input int st, input int iw, input int gp);
    bit fail_exp, split_exp;
    int waited;
    ext_platform = plat; ext_en = exten; zero_polls = zp; max_polls = 8'(mp);
    settle_cycles = TW'(st); id_wait_cycles = TW'(iw); gap_cycles = TW'(gp);
    id_val = (idhi ? 32'h8000_0000 : 32'h0) | 32'h00C2_1F40 | 32'(st + gp);
    ext_sig = good ? 32'h444C5754 : 32'h444C5755;
    id_cmds = 0; hdr_cmds = 0; ext_cmds = 0;
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    chk(!done && !err && busy, "R13 restart clears status", {done, err, busy}, 3'b001);
    waited = 0;
    while (!done && waited < 6000) begin @(negedge clk); waited++; end
    chk(done, "R5 sequence ends", done, 1);
    fail_exp = (zp >= (mp < 1 ? 1 : mp));
    split_exp = plat && idhi;
    repeat (4) @(negedge clk);
    chk(!cmd_valid && done, "R5 quiet after end", cmd_valid, 0);
    if (fail_exp) begin
      chk(err, "R5 error flag", err, 1);
      chk(id_cmds == (mp < 1 ? 1 : mp), "R5 poll count", id_cmds, (mp < 1 ? 1 : mp));
      chk(hdr_cmds == 0, "R5 no header read", hdr_cmds, 0);
    end else begin
      chk(!err, "R4 no error", err, 0);
      chk(chip_id == id_val, "R4 chip id", chip_id, id_val);
      chk(id_cmds == zp + 1, "R4 re-poll count", id_cmds, zp + 1);
      chk(split_mode == split_exp, "R7 split flag", split_mode, split_exp);
      if (split_exp) begin
        chk(hdr_cmds == NP, "R7 piece count", hdr_cmds, NP);
        for (int k = 0; k < NP; k++)
          chk(hdr_addr[k] == 32'(k*SB) && hdr_xw[k] == SW, "R7 piece addr", hdr_addr[k], 32'(k*SB));
      end else begin
        chk(hdr_cmds == 1 && hdr_addr[0] == 0 && hdr_xw[0] == HW, "R8 single read", hdr_xw[0], HW);
      end
      chk(ext_cmds == (exten ? 1 : 0), "R11 ext cmd count", ext_cmds, exten);
      chk(ext_valid == (exten && good), "R11 ext signature", ext_valid, exten && good);
      for (int i = 0; i < HW; i++) begin
        rd_addr = AW'(i);
        @(negedge clk);
        chk(rd_data == pat(32'(4*i)), "R10 buffer word", rd_data, pat(32'(4*i)));
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!cart_rst_n && !busy && !done && !err && !ext_valid && !cmd_valid && !rsp_ready,
        "R1 reset state", {cart_rst_n, busy, done, err, ext_valid, cmd_valid, rsp_ready}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(!cart_rst_n && !busy, "R1 idle holds cartridge", cart_rst_n, 0);
    for (int c = 0; c < 16; c++)
      run(c[0], c[1], c[2], c[3], c % 3, 3, (c % 3) * 2, c % 3, c % 4);
    run(1, 1, 1, 1, 2, 3, 1, 0, 5);   // boundary: success on last allowed poll
    run(0, 1, 0, 0, 3, 3, 0, 2, 1);   // exactly max_polls zeros
    run(1, 0, 0, 0, 5, 2, 3, 0, 0);   // more zeros than allowed
    run(1, 1, 0, 0, 0, 1, 0, 0, 0);   // single poll allowed, ready at once
    run(0, 0, 0, 0, 4, 0, 0, 0, 0);   // zero limit still sends one poll
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule